// File: doc/BRIEF.md
# Prioritizing interrupt request controller

This block collects eight interrupt request lines from peripherals and drives one interrupt output to a processor. A rising edge on a line latches a pending request. The block picks the best pending request that is not masked. It raises the interrupt output only when that request ranks above every line the processor is still servicing. When the processor pulses acknowledge, the block shows the winning line index on the vector output in that same cycle and moves the request into service. The line stays in service until an end-of-interrupt command retires it.

Software uses a small write-only configuration port. Through it, software sets the mask, chooses one of three priority orderings and names the lowest-priority line. The same port issues end-of-interrupt commands. There are three orderings. Fixed ordering always favours line 0. Rotating ordering demotes a line to lowest priority once it is retired. Specific ordering uses a lowest line that software programs. In rotating and specific ordering, the lines rank in circular order starting from the line just after the lowest one.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, all pending and in-service state is empty, every line is masked (so a request gives no interrupt), and the ordering is fixed.
- R2: A request is latched only on a rising edge of its line. A line held high after acknowledge produces no second request.
- R3: A masked line is still latched as pending but never raises the interrupt. Writing mask bit i = 0 (address 0, bit i = 1 masks line i) lets an already latched request raise the interrupt with no new edge.
- R4: While the interrupt output is high, the vector output gives the winning line index. An acknowledge in that cycle clears the line's pending bit and sets its in-service bit, so the output drops if nothing else qualifies.
- R5: The interrupt is raised only when the winning pending line ranks strictly above every in-service line. A higher line can therefore nest over a lower one, but an equal or lower line cannot.
- R6: In fixed ordering (address 1, data bits [1:0] = 00 or 11), a lower line number always wins.
- R7: In rotating ordering (address 1, code 01), a line retired by end-of-interrupt becomes the lowest priority and its successor becomes the highest.
- R8: In specific ordering (address 1, code 10), the line written to address 2 (bits [2:0]) is lowest and the others follow circularly. End-of-interrupt does not change that line.
- R9: A non-specific end-of-interrupt (address 3, bit 3 = 0) clears the highest-ranked in-service bit.
- R10: A specific end-of-interrupt (address 3, bit 3 = 1, line index in bits [2:0]) clears only the named in-service bit.
- R11: An acknowledge while the interrupt output is low changes no state.
- R12: A rising edge on a line in the same cycle as its acknowledge leaves a new pending request for that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| irq_in | input | 8 | Request lines from peripherals |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select: 0 mask, 1 ordering, 2 lowest line, 3 end-of-interrupt |
| cfg_wdata | input | 8 | Configuration write data |
| ack | input | 1 | Acknowledge pulse from the processor |
| int_out | output | 1 | Interrupt request to the processor |
| ack_vec | output | 3 | Index of the winning line, valid while int_out is high |

## Verification
Wrong internal state shows up at the ports in one of two ways. The interrupt output can rise or fall in the wrong cycle, or the vector can name the wrong line. Each such error is visible on the first clock after the faulty update.

A wrong in-service or lowest-line value may show nothing until a competing request arrives. The bench therefore builds nested and circular arrangements in which a pending line sits between two in-service lines. In those arrangements a single wrong bit flips the output within one cycle. A reference model compares both outputs on every clock.

// File: rtl/pic_pkg.sv
package pic_pkg;

  typedef enum logic [1:0] {
    PRIO_FIXED    = 2'b00,
    PRIO_ROTATE   = 2'b01,
    PRIO_SPECIFIC = 2'b10
  } prio_mode_e;

  localparam logic [1:0] CFG_MASK   = 2'd0;
  localparam logic [1:0] CFG_MODE   = 2'd1;
  localparam logic [1:0] CFG_LOWEST = 2'd2;
  localparam logic [1:0] CFG_EOI    = 2'd3;

  // Unused code 11 falls back to fixed ordering.
  function automatic prio_mode_e decode_mode(input logic [1:0] code);
    case (code)
      2'b01:   return PRIO_ROTATE;
      2'b10:   return PRIO_SPECIFIC;
      default: return PRIO_FIXED;
    endcase
  endfunction

endpackage

// File: rtl/pic_reset_sync.sv
module pic_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/pic_edge_detect.sv
module pic_edge_detect #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);

  logic [N-1:0] prev_q;
  logic         prev_en;

  assign prev_en = |(lvl ^ prev_q);
  assign rise    = lvl & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prev_q <= '0;
    else if (prev_en) prev_q <= lvl;
  end

endmodule

// File: rtl/pic_prio_resolver.sv
// Picks the set bit of highest rank; rank 0 is the line just after 'low'.
module pic_prio_resolver #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  vec,
  input  logic [IW-1:0] low,
  output logic          valid,
  output logic [IW-1:0] idx,
  output logic [IW-1:0] rank
);

  always_comb begin
    int line;
    valid = 1'b0;
    idx   = '0;
    rank  = '0;
    line  = 0;
    for (int r = N - 1; r >= 0; r--) begin
      line = (int'(low) + 1 + r) % N;
      if (vec[line]) begin
        valid = 1'b1;
        idx   = IW'(line);
        rank  = IW'(r);
      end
    end
  end

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import pic_pkg::*;
#(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_in,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [N-1:0]  cfg_wdata,
  input  logic          ack,
  output logic          int_out,
  output logic [IW-1:0] ack_vec
);

  logic          rst_sync_n;
  logic [N-1:0]  rise;

  logic [N-1:0]  irr_q, irr_d, isr_q, isr_d, mask_q, mask_d;
  prio_mode_e    mode_q, mode_d;
  logic [IW-1:0] low_q, low_d, eff_low;
  logic          irr_en, isr_en, mask_en, mode_en, low_en;

  logic          pend_valid, svc_valid;
  logic [IW-1:0] pend_idx, pend_rank, svc_idx, svc_rank;

  logic          take, wr_mask, wr_mode, wr_low, wr_eoi, eoi_spec, clr_hit;
  logic [IW-1:0] clr_idx;
  logic [N-1:0]  take_oh, clr_oh;

  pic_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pic_edge_detect #(.N(N)) u_edge (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .lvl   (irq_in),
    .rise  (rise)
  );

  assign eff_low = (mode_q == PRIO_FIXED) ? IW'(N - 1) : low_q;

  pic_prio_resolver #(.N(N), .IW(IW)) u_pend (
    .vec   (irr_q & ~mask_q),
    .low   (eff_low),
    .valid (pend_valid),
    .idx   (pend_idx),
    .rank  (pend_rank)
  );

  pic_prio_resolver #(.N(N), .IW(IW)) u_svc (
    .vec   (isr_q),
    .low   (eff_low),
    .valid (svc_valid),
    .idx   (svc_idx),
    .rank  (svc_rank)
  );

  assign int_out = pend_valid && (!svc_valid || (pend_rank < svc_rank));
  assign ack_vec = pend_idx;

  assign take     = ack && int_out;
  assign wr_mask  = cfg_we && (cfg_addr == CFG_MASK);
  assign wr_mode  = cfg_we && (cfg_addr == CFG_MODE);
  assign wr_low   = cfg_we && (cfg_addr == CFG_LOWEST);
  assign wr_eoi   = cfg_we && (cfg_addr == CFG_EOI);
  assign eoi_spec = cfg_wdata[IW];

  // Next-state logic
  always_comb begin
    take_oh = '0;
    if (take) take_oh[pend_idx] = 1'b1;

    clr_idx = eoi_spec ? cfg_wdata[IW-1:0] : svc_idx;
    clr_hit = wr_eoi && (eoi_spec ? isr_q[clr_idx] : svc_valid);
    clr_oh  = '0;
    if (clr_hit) clr_oh[clr_idx] = 1'b1;

    irr_d  = (irr_q & ~take_oh) | rise;
    irr_en = take || (|rise);

    isr_d  = (isr_q | take_oh) & ~clr_oh;
    isr_en = take || clr_hit;

    mask_d  = cfg_wdata;
    mask_en = wr_mask;

    mode_d  = decode_mode(cfg_wdata[1:0]);
    mode_en = wr_mode;

    low_d  = wr_low ? cfg_wdata[IW-1:0] : clr_idx;
    low_en = wr_low || (clr_hit && (mode_q == PRIO_ROTATE));
  end

  // State registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      irr_q  <= '0;
      isr_q  <= '0;
      mask_q <= '1;
      mode_q <= PRIO_FIXED;
      low_q  <= IW'(N - 1);
    end else begin
      if (irr_en)  irr_q  <= irr_d;
      if (isr_en)  isr_q  <= isr_d;
      if (mask_en) mask_q <= mask_d;
      if (mode_en) mode_q <= mode_d;
      if (low_en)  low_q  <= low_d;
    end
  end

endmodule

// File: rtl/pic_checker.sv
module pic_checker #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack,
  input logic          cfg_we,
  input logic          int_out,
  input logic [IW-1:0] ack_vec,
  input logic [N-1:0]  irr,
  input logic [N-1:0]  isr,
  input logic [N-1:0]  mask,
  input logic [1:0]    mode
);

  // R4: new in-service bits appear only after a granted acknowledge
  p_service_from_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(isr & ~$past(isr))) |-> $past(ack && int_out));

  // R4: a granted acknowledge puts the vectored line in service
  p_ack_enters_service_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && int_out && !cfg_we) |=> isr[$past(ack_vec)]);

  // R5: at most one line enters service per cycle
  p_single_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(isr & ~$past(isr)) <= 1);

  // R3: the interrupt names a pending, unmasked line
  p_int_unmasked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> (irr[ack_vec] && !mask[ack_vec]));

  // R5: the vectored line is never one already in service
  p_no_self_nest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> !isr[ack_vec]);

  // R6: the unused ordering code is never stored
  p_mode_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11);

endmodule

bind irq_prio_ctrl pic_checker #(.N(N), .IW(IW)) u_pic_checker (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .ack     (ack),
  .cfg_we  (cfg_we),
  .int_out (int_out),
  .ack_vec (ack_vec),
  .irr     (irr_q),
  .isr     (isr_q),
  .mask    (mask_q),
  .mode    (mode_q)
);

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] irq;
  logic       cfg_we;
  logic [1:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic       ack;
  logic       int_out;
  logic [2:0] ack_vec;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  irq_prio_ctrl #(.N(8)) i_irq_prio_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .ack       (ack),
    .int_out   (int_out),
    .ack_vec   (ack_vec)
  );

  // ---------------- reference model ----------------
  bit [7:0] m_irr, m_isr, m_mask, m_prev, setm, clrm;
  int       m_mode, m_low, el, mp, ms, ci;

  function automatic int rnk(int line, int low);
    return (line - low - 1 + 16) % 8;
  endfunction

  function automatic int best(bit [7:0] v, int low);
    int b = -1;
    for (int i = 0; i < 8; i++)
      if (v[i] && (b < 0 || rnk(i, low) < rnk(b, low))) b = i;
    return b;
  endfunction

  function automatic int eff_low();
    return (m_mode == 0) ? 7 : m_low;
  endfunction

  function automatic bit model_int();
    int p = best(m_irr & ~m_mask, eff_low());
    int s = best(m_isr, eff_low());
    return (p >= 0) && (s < 0 || rnk(p, eff_low()) < rnk(s, eff_low()));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_irr = 0; m_isr = 0; m_mask = 8'hFF; m_prev = 0; m_mode = 0; m_low = 7;
    end else begin
      el = eff_low();
      mp = best(m_irr & ~m_mask, el);
      ms = best(m_isr, el);
      setm = 0; clrm = 0;
      if (ack && model_int()) setm[mp] = 1'b1;
      if (cfg_we && cfg_addr == 2'd3) begin
        ci = cfg_wdata[3] ? int'(cfg_wdata[2:0]) : ms;
        if (ci >= 0 && m_isr[ci]) begin
          clrm[ci] = 1'b1;
          if (m_mode == 1) m_low = ci;
        end
      end
      if (cfg_we && cfg_addr == 2'd0) m_mask = cfg_wdata;
      if (cfg_we && cfg_addr == 2'd1)
        m_mode = (cfg_wdata[1:0] == 2'b01) ? 1 : (cfg_wdata[1:0] == 2'b10) ? 2 : 0;
      if (cfg_we && cfg_addr == 2'd2) m_low = int'(cfg_wdata[2:0]);
      m_irr  = (m_irr & ~setm) | (irq & ~m_prev);
      m_prev = irq;
      m_isr  = (m_isr | setm) & ~clrm;
    end
  end

  // Per-cycle comparison against the model (R4, R5)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      tests++;
      if (int_out !== model_int()) begin
        fails++;
        $display("FAIL R5 model int_out: actual %0b expected %0b at %0t", int_out, model_int(), $time);
      end else if (model_int() && int'(ack_vec) != best(m_irr & ~m_mask, eff_low())) begin
        fails++;
        $display("FAIL R4 model ack_vec: actual %0d expected %0d at %0t",
                 ack_vec, best(m_irr & ~m_mask, eff_low()), $time);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    step();
    ack = 1'b0;
  endtask

  task automatic pulse_irq(logic [7:0] bits);
    irq = irq | bits;
    step();
    irq = irq & ~bits;
    step();
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq = '0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; ack = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // Phase A: reset, masking, edge latching, ignored acknowledge
    do_reset();
    chk("R1 int_out after reset", int_out, 0);
    irq[2] = 1'b1; step();
    chk("R1 lines masked after reset", int_out, 0);
    pulse_ack();
    chk("R11 ack with int_out low", int_out, 0);
    wr(2'd0, 8'h00);
    chk("R3 unmask raises latched request", int_out, 1);
    chk("R11 request survived ignored ack", ack_vec, 2);
    pulse_ack();
    chk("R4 ack moves request to service", int_out, 0);
    repeat (3) step();
    chk("R2 held level gives no new request", int_out, 0);
    wr(2'd3, 8'h00);
    chk("R2 no request after EOI while level held", int_out, 0);
    irq[2] = 1'b0; step();
    wr(2'd0, 8'h20);
    pulse_irq(8'h20);
    chk("R3 masked line gives no interrupt", int_out, 0);
    wr(2'd0, 8'h00);
    chk("R3 masked line was latched", ack_vec, 5);

    // Phase B: fixed ordering, nesting, EOI kinds
    do_reset();
    wr(2'd0, 8'h00);
    pulse_irq(8'h28);
    chk("R6 lower line wins", ack_vec, 3);
    pulse_ack();
    chk("R5 lower line cannot nest", int_out, 0);
    pulse_irq(8'h02);
    chk("R5 higher line nests", int_out, 1);
    chk("R5 nesting vector", ack_vec, 1);
    pulse_ack();
    pulse_irq(8'h04);
    chk("R5 line between services waits", int_out, 0);
    wr(2'd3, 8'h00);
    chk("R9 non-specific EOI clears top service", int_out, 1);
    chk("R9 vector after EOI", ack_vec, 2);
    pulse_ack();
    wr(2'd3, 8'h0B);
    pulse_irq(8'h04);
    chk("R10 specific EOI keeps other service", int_out, 0);
    wr(2'd3, 8'h00);
    chk("R10 remaining service cleared", int_out, 1);
    chk("R10 vector", ack_vec, 2);

    // Phase C: rotating ordering
    do_reset();
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h01);
    pulse_irq(8'h03);
    chk("R7 initial rotating winner", ack_vec, 0);
    pulse_ack();
    wr(2'd3, 8'h00);
    chk("R7 successor wins after EOI", ack_vec, 1);
    pulse_irq(8'h01);
    chk("R7 retired line now lowest", ack_vec, 1);

    // Phase D: specific ordering
    do_reset();
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h02);
    wr(2'd2, 8'h04);
    pulse_irq(8'h48);
    chk("R8 circular order from lowest", ack_vec, 6);
    pulse_ack();
    wr(2'd3, 8'h00);
    chk("R8 remaining request", ack_vec, 3);
    pulse_irq(8'h40);
    chk("R8 EOI does not move lowest line", ack_vec, 6);

    // Phase E: edge coinciding with acknowledge
    do_reset();
    wr(2'd0, 8'h00);
    pulse_irq(8'h10);
    chk("R12 request raised", ack_vec, 4);
    ack = 1'b1; irq[4] = 1'b1;
    step();
    ack = 1'b0; irq[4] = 1'b0;
    chk("R12 no interrupt while same line in service", int_out, 0);
    wr(2'd3, 8'h00);
    chk("R12 new request kept", int_out, 1);
    chk("R12 vector", ack_vec, 4);

    step();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule